// File: doc/BRIEF.md
# Staged Over-Temperature Alarm

This block watches a sampled die temperature, given in millidegrees Celsius as a signed word, and sorts it into one of four severity stages (0 to 3). Three trip levels set the stages. They sit 20 °C apart. A 2-bit threshold code moves all three together in 5 °C steps, starting from 105 °C at code 0. A stage is entered when the temperature reaches its trip level. It is left only when the temperature falls 2 °C below that level, so a reading near a boundary does not make the stage toggle.

Software reaches the block through a synchronous byte port. A write happens on the clock edge while the write strobe is high. Read data is a combinational function of the address. The port exposes two fixed identification bytes, a status byte, a threshold byte and an alarm-enable byte. Every change of the stage sets a pending flag, which drives the interrupt line. Software clears the flag by writing a 1 to bit 7 of the status byte. While the alarm is not enabled, the stage is forced to 0 and no interrupt is raised.

Top module: `thermal_alarm_regs`

## Requirements
- R1: The byte at offset 0x04 reads 0x09 and the byte at offset 0x05 reads 0x08. Writes to either offset leave them unchanged.
- R2: After reset:
  - the threshold code is 0 and the alarm is disabled;
  - the status byte reads 0x00;
  - irq is low.
- R3: While bit 7 of the alarm byte (offset 0x46) is 0, the stage is held at 0 and the pending flag never sets. Clearing that bit while the stage is non-zero returns the stage to 0 without raising an interrupt.
- R4: With the alarm enabled, a rising temperature T moves the stage to the number of trip levels k (k = 1, 2, 3) with T >= 105000 + 5000*code + 20000*(k-1) mC. The stage can jump several levels at once. The status byte shows the stage in bits [1:0] one clock after T is applied.
- R5: Bits [1:0] of the byte at offset 0x40 hold the threshold code, which is read/write. The other bits of that byte read 0. A new code takes effect on the next clock.
- R6: The stage falls to a lower value only when T drops below the trip level of a higher stage minus 2000 mC. The new stage is the number of levels k for which T >= trip_k - 2000 still holds.
- R7: Any change of the stage while the alarm is enabled sets the pending flag. The flag drives irq high and reads back as status bit 7.
- R8: Writing a byte with bit 7 set to offset 0x08 clears the pending flag. Writing bit 7 as 0 has no effect. The stage bits cannot be written.
- R9: If a stage change and a clearing write fall on the same clock edge, the pending flag stays set.
- R10: Writes to any offset other than 0x08, 0x40 and 0x46 are ignored. Reads from unused offsets return 0x00. In the alarm byte, only bit 7 is stored; its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_mc | input | TEMP_W (20) | Signed sampled temperature in millidegrees Celsius |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Active-high interrupt, equal to the pending flag |

## Verification
Two events can land on the same clock edge: a stage change that sets the pending flag, and a software write that clears it. The bench provokes this by changing the temperature across a release level in the same cycle that it writes 0x80 to the status offset. It then expects the status byte to show both the new stage and a pending flag that is still set, with irq high. A second case covers disabling the alarm while the stage is non-zero. There the stage returns to 0, and the bench expects irq to stay low.

// File: rtl/thalm_pkg.sv
package thalm_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned OFF_TYPE   = 'h04;
   localparam int unsigned OFF_SUBTY  = 'h05;
   localparam int unsigned OFF_STATUS = 'h08;
   localparam int unsigned OFF_THRESH = 'h40;
   localparam int unsigned OFF_ALARM  = 'h46;
   localparam int unsigned PEND_BIT   = 7;
   localparam int unsigned ENA_BIT    = 7;
endpackage

// File: rtl/thalm_stage_eval.sv
module thalm_stage_eval #(
   parameter int TEMP_W        = 20,
   parameter int NUM_STAGES    = 3,
   parameter int STAGE_W       = 2,
   parameter int CODE_W        = 2,
   parameter int BASE_MC       = 105000,
   parameter int THR_STEP_MC   = 5000,
   parameter int STAGE_STEP_MC = 20000,
   parameter int HYST_MC       = 2000
) (
   input  logic signed [TEMP_W-1:0] temp_mc,
   input  logic [CODE_W-1:0]        thr_code,
   input  logic [STAGE_W-1:0]       cur_stage,
   output logic [STAGE_W-1:0]       next_stage
);
   localparam int EXT_W = 32 - TEMP_W;

   logic signed [31:0] temp_ext;
   logic signed [31:0] code_off;
   logic [NUM_STAGES-1:0] rise_hit;
   logic [NUM_STAGES-1:0] hold_hit;
   logic [STAGE_W-1:0] up_cnt;
   logic [STAGE_W-1:0] hold_cnt;

   assign temp_ext = {{EXT_W{temp_mc[TEMP_W-1]}}, temp_mc};
   assign code_off = $signed(32'(thr_code)) * THR_STEP_MC;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_trip
      logic signed [31:0] trip_mc;
      assign trip_mc     = BASE_MC + code_off + k * STAGE_STEP_MC;
      assign rise_hit[k] = temp_ext >= trip_mc;
      assign hold_hit[k] = temp_ext >= (trip_mc - HYST_MC);
   end

   always_comb begin
      up_cnt   = '0;
      hold_cnt = '0;
      for (int k = 0; k < NUM_STAGES; k++) begin
         if (rise_hit[k]) up_cnt   = up_cnt + STAGE_W'(1);
         if (hold_hit[k]) hold_cnt = hold_cnt + STAGE_W'(1);
      end
      if (up_cnt > cur_stage)
         next_stage = up_cnt;
      else if (hold_cnt < cur_stage)
         next_stage = hold_cnt;
      else
         next_stage = cur_stage;
   end
endmodule

// File: rtl/thalm_stage_track.sv
module thalm_stage_track #(
   parameter int STAGE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alarm_en,
   input  logic [STAGE_W-1:0] next_stage,
   output logic [STAGE_W-1:0] stage_q,
   output logic               stage_evt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage_q <= '0;
      else if (!alarm_en)
         stage_q <= '0;
      else
         stage_q <= next_stage;
   end

   assign stage_evt = alarm_en && (next_stage != stage_q);
endmodule

// File: rtl/thalm_regs.sv
module thalm_regs
   import thalm_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          CODE_W   = 2,
   parameter int          STAGE_W  = 2,
   parameter logic [7:0]  TYPE_ID  = 8'h09,
   parameter logic [7:0]  SUBTY_ID = 8'h08
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   input  logic [STAGE_W-1:0] stage,
   input  logic               stage_evt,
   output logic [7:0]         bus_rdata,
   output logic [CODE_W-1:0]  thr_code,
   output logic               alarm_en,
   output logic               pending
);
   logic hit_status, hit_thresh, hit_alarm, hit_type, hit_subty;
   logic clr_req;

   assign hit_type   = bus_addr == ADDR_W'(OFF_TYPE);
   assign hit_subty  = bus_addr == ADDR_W'(OFF_SUBTY);
   assign hit_status = bus_addr == ADDR_W'(OFF_STATUS);
   assign hit_thresh = bus_addr == ADDR_W'(OFF_THRESH);
   assign hit_alarm  = bus_addr == ADDR_W'(OFF_ALARM);
   assign clr_req    = bus_wr && hit_status && bus_wdata[PEND_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_code <= '0;
         alarm_en <= 1'b0;
      end else if (bus_wr) begin
         if (hit_thresh) thr_code <= bus_wdata[CODE_W-1:0];
         if (hit_alarm)  alarm_en <= bus_wdata[ENA_BIT];
      end
   end

   // a fresh stage change outranks a clearing write on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending <= 1'b0;
      else if (stage_evt)
         pending <= 1'b1;
      else if (clr_req)
         pending <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_type)
         bus_rdata = TYPE_ID;
      else if (hit_subty)
         bus_rdata = SUBTY_ID;
      else if (hit_status) begin
         bus_rdata           = 8'(stage);
         bus_rdata[PEND_BIT] = pending;
      end else if (hit_thresh)
         bus_rdata = 8'(thr_code);
      else if (hit_alarm)
         bus_rdata[ENA_BIT] = alarm_en;
   end
endmodule

// File: rtl/thermal_alarm_regs.sv
module thermal_alarm_regs #(
   parameter int         TEMP_W        = 20,
   parameter int         ADDR_W        = 8,
   parameter int         NUM_STAGES    = 3,
   parameter int         CODE_W        = 2,
   parameter int         BASE_MC       = 105000,
   parameter int         THR_STEP_MC   = 5000,
   parameter int         STAGE_STEP_MC = 20000,
   parameter int         HYST_MC       = 2000,
   parameter logic [7:0] TYPE_ID       = 8'h09,
   parameter logic [7:0] SUBTY_ID      = 8'h08
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [TEMP_W-1:0] temp_mc,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [7:0]               bus_wdata,
   output logic [7:0]               bus_rdata,
   output logic                     irq
);
   localparam int STAGE_W = $clog2(NUM_STAGES + 1);

   initial begin
      assert (NUM_STAGES >= 1 && STAGE_W <= 7)
         else $error("NUM_STAGES must fit below the pending bit");
      assert (TEMP_W >= 8 && TEMP_W < 32) else $error("TEMP_W out of range");
      assert (ADDR_W >= 7) else $error("ADDR_W too narrow for the offsets");
      assert (CODE_W >= 1 && CODE_W <= 7) else $error("CODE_W out of range");
      assert (HYST_MC >= 0 && HYST_MC < STAGE_STEP_MC)
         else $error("HYST_MC must be below the stage spacing");
   end

   logic [CODE_W-1:0]  thr_code;
   logic               alarm_en;
   logic               pending;
   logic [STAGE_W-1:0] stage_q;
   logic [STAGE_W-1:0] next_stage;
   logic               stage_evt;

   thalm_stage_eval #(
      .TEMP_W(TEMP_W), .NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W),
      .CODE_W(CODE_W), .BASE_MC(BASE_MC), .THR_STEP_MC(THR_STEP_MC),
      .STAGE_STEP_MC(STAGE_STEP_MC), .HYST_MC(HYST_MC)
   ) u_eval (
      .temp_mc(temp_mc), .thr_code(thr_code),
      .cur_stage(stage_q), .next_stage(next_stage)
   );

   thalm_stage_track #(.STAGE_W(STAGE_W)) u_track (
      .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en),
      .next_stage(next_stage), .stage_q(stage_q), .stage_evt(stage_evt)
   );

   thalm_regs #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .STAGE_W(STAGE_W),
      .TYPE_ID(TYPE_ID), .SUBTY_ID(SUBTY_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .stage(stage_q), .stage_evt(stage_evt),
      .bus_rdata(bus_rdata), .thr_code(thr_code), .alarm_en(alarm_en),
      .pending(pending)
   );

   assign irq = pending;
endmodule

// File: rtl/thalm_checker.sv
module thalm_checker #(
   parameter int         ADDR_W   = 8,
   parameter int         STAGE_W  = 2,
   parameter logic [7:0] TYPE_ID  = 8'h09,
   parameter logic [7:0] SUBTY_ID = 8'h08
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic [STAGE_W-1:0] stage,
   input logic               alarm_en,
   input logic               pending,
   input logic               irq
);
   logic unused_off;
   assign unused_off = (bus_addr != ADDR_W'('h04)) && (bus_addr != ADDR_W'('h05)) &&
                       (bus_addr != ADDR_W'('h08)) && (bus_addr != ADDR_W'('h40)) &&
                       (bus_addr != ADDR_W'('h46));

   p_type_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'('h04) |-> bus_rdata == TYPE_ID);
   p_subty_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'('h05) |-> bus_rdata == SUBTY_ID);
   p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unused_off |-> bus_rdata == 8'h00);
   p_idle_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_en |=> stage == '0);
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_en |=> !$rose(pending));
   p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> stage != $past(stage));
   p_change_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_en |=> (stage == $past(stage)) || pending);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h08) && bus_wdata[7])
         |=> (!pending || stage != $past(stage)));
   p_irq_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> irq);
endmodule

bind thermal_alarm_regs thalm_checker #(
   .ADDR_W(ADDR_W), .STAGE_W(STAGE_W), .TYPE_ID(TYPE_ID), .SUBTY_ID(SUBTY_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stage(stage_q),
   .alarm_en(alarm_en), .pending(pending), .irq(irq)
);

// File: tb/thermal_alarm_regs_test.sv
module thermal_alarm_regs_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [19:0] temp_mc = '0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic irq;

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] addr;
      logic [7:0] exp_data;
      logic       exp_irq;
      string      req;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   thermal_alarm_regs uut (
      .clk(clk), .rst_n(rst_n), .temp_mc(temp_mc), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // monitor: pop one expected item per cycle and compare away from the edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_run++;
         if (bus_rdata !== e.exp_data || irq !== e.exp_irq) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual data=%02h irq=%0b expected data=%02h irq=%0b",
                     e.req, e.addr, bus_rdata, irq, e.exp_data, e.exp_irq);
         end
      end
   end

   task automatic expect_reg(input logic [7:0] a, input logic [7:0] d,
                             input logic i, input string req);
      exp_t e;
      @(posedge clk); #1;
      bus_addr = a;
      e.addr = a; e.exp_data = d; e.exp_irq = i; e.req = req;
      sb.push_back(e);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic set_temp(input int t);
      @(posedge clk); #1;
      temp_mc = 20'(t);
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 5000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R2 reset state, R1 identification
      expect_reg(8'h04, 8'h09, 1'b0, "R1 type id");
      expect_reg(8'h05, 8'h08, 1'b0, "R1 subtype id");
      expect_reg(8'h08, 8'h00, 1'b0, "R2 status after reset");
      expect_reg(8'h40, 8'h00, 1'b0, "R2 threshold after reset");
      expect_reg(8'h46, 8'h00, 1'b0, "R2 alarm disabled after reset");
      expect_reg(8'h00, 8'h00, 1'b0, "R10 unused offset reads zero");
      wr_reg(8'h04, 8'hFF);
      expect_reg(8'h04, 8'h09, 1'b0, "R1 type not writable");
      wr_reg(8'h10, 8'hFF);
      expect_reg(8'h10, 8'h00, 1'b0, "R10 unused write ignored");
      expect_reg(8'h46, 8'h00, 1'b0, "R10 unused write left alarm byte");
      // R3 disabled alarm ignores heat
      set_temp(150000);
      expect_reg(8'h08, 8'h00, 1'b0, "R3 disabled holds stage 0");
      // R4 enable at 150 C with code 0 -> stage 3
      wr_reg(8'h46, 8'hFF);
      expect_reg(8'h08, 8'h83, 1'b1, "R4 R7 jump to stage 3");
      expect_reg(8'h46, 8'h80, 1'b1, "R10 only enable bit stored");
      // R8 clearing
      wr_reg(8'h08, 8'h03);
      expect_reg(8'h08, 8'h83, 1'b1, "R8 bit7 zero keeps pending");
      wr_reg(8'h08, 8'h80);
      expect_reg(8'h08, 8'h03, 1'b0, "R8 clear pending");
      // R6 hysteresis on the 145 C level (release below 143 C)
      set_temp(143500);
      expect_reg(8'h08, 8'h03, 1'b0, "R6 stays in stage 3 inside band");
      set_temp(142999);
      expect_reg(8'h08, 8'h82, 1'b1, "R6 R7 falls to stage 2");
      wr_reg(8'h08, 8'h80);
      set_temp(124000);
      expect_reg(8'h08, 8'h02, 1'b0, "R6 stays in stage 2 inside band");
      set_temp(100000);
      expect_reg(8'h08, 8'h80, 1'b1, "R6 multi-level fall to stage 0");
      wr_reg(8'h08, 8'h80);
      expect_reg(8'h08, 8'h00, 1'b0, "R8 clear after fall");
      // R4 boundary at 105 C
      set_temp(104999);
      expect_reg(8'h08, 8'h00, 1'b0, "R4 just below first trip");
      set_temp(105000);
      expect_reg(8'h08, 8'h81, 1'b1, "R4 exactly at first trip");
      wr_reg(8'h08, 8'h80);
      // R5 threshold code 3: trips 120/140/160, first release 118 C
      wr_reg(8'h40, 8'hFF);
      expect_reg(8'h08, 8'h80, 1'b1, "R5 raised trips drop stage 1 to 0");
      expect_reg(8'h40, 8'h03, 1'b1, "R5 code field readback");
      wr_reg(8'h08, 8'h80);
      set_temp(139999);
      expect_reg(8'h08, 8'h81, 1'b1, "R5 code 3 stage 1 below 140 C");
      set_temp(140000);
      expect_reg(8'h08, 8'h82, 1'b1, "R5 code 3 stage 2 at 140 C");
      wr_reg(8'h08, 8'h80);
      expect_reg(8'h08, 8'h02, 1'b0, "R8 clear at stage 2");
      // R9 stage change and clear on the same edge
      @(posedge clk); #1;
      temp_mc = 20'(137000);
      bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 8'h80;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      expect_reg(8'h08, 8'h81, 1'b1, "R9 set beats clear");
      wr_reg(8'h08, 8'h80);
      expect_reg(8'h08, 8'h01, 1'b0, "R8 clear after collision");
      // R3 disabling from stage 1 quietly returns to 0
      wr_reg(8'h46, 8'h00);
      expect_reg(8'h08, 8'h00, 1'b0, "R3 disable returns stage 0 without irq");
      set_temp(200000);
      expect_reg(8'h08, 8'h00, 1'b0, "R3 disabled ignores 200 C");
      expect_reg(8'h08, 8'h00, 1'b0, "R3 still quiet");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule